// File: doc/BRIEF.md
# Two-Tier Carry-Lookahead Adder

This block adds two 16-bit operands and a carry input in one combinational pass. Each bit position forms a propagate term (the OR of its operand bits) and a generate term (their AND). The bits are split into groups of four. Each group has a first-tier lookahead unit that reduces its terms to one group propagate and one group generate.

A second-tier lookahead unit takes those group terms and the carry input and forms a seed carry for every group. It uses the same flat sum-of-products equations that a first-tier unit applies to bits. Each first-tier unit then combines its seed carry with its own bit terms to form its internal carries. Each sum bit is the XOR of the two operand bits and the incoming carry. The longest path is nine gate levels: one for bit terms, then two each for group terms, seed carries, internal carries and sums.

The block-wide propagate and generate are brought out. Four copies of this adder and one more lookahead unit can therefore form a 64-bit adder.

Top module: `cla16_adder`

## Requirements
- R1: `sum` equals the low 16 bits of `op_a + op_b + carry_in` for every input combination.
- R2: `carry_out` equals bit 16 of `op_a + op_b + carry_in`, and it agrees with the carry that the highest group's own lookahead unit forms from that group's seed.
- R3: `blk_gen` is 1 exactly when `op_a + op_b`, with no carry input, reaches 2^16 or more.
- R4: `blk_prop` is 1 exactly when every bit position has at least one operand bit set, i.e. `(op_a | op_b)` is all ones. Both bits set counts as propagating.
- R5: `carry_out` equals `blk_gen | (blk_prop & carry_in)`.
- R6: `blk_prop` and `blk_gen` do not depend on `carry_in`. Toggling `carry_in` with fixed operands leaves both unchanged.
- R7: A carry input crosses all four groups in one pass. For example, `0xFFFF + 0x0000 + 1` gives `sum = 0x0000` and `carry_out = 1`, and `0xAAAA + 0x5555 + 1` gives the same result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | 16 | First operand |
| op_b | input | 16 | Second operand |
| carry_in | input | 1 | Carry into bit 0 |
| sum | output | 16 | Sum bits |
| carry_out | output | 1 | Carry out of bit 15 |
| blk_prop | output | 1 | Block-wide propagate, for a further lookahead tier |
| blk_gen | output | 1 | Block-wide generate, for a further lookahead tier |

## Verification
The block holds no state, so a wrong lookahead term shows at the ports as soon as the inputs settle. A broken seed carry corrupts every sum bit of its group whenever a carry has to cross a group boundary. Vectors that make carries cross one, several or all group boundaries are therefore the ones that expose faults. A wrong block-level term shows in `blk_prop` or `blk_gen`, or through the relation R5 between them and `carry_out`.

// File: rtl/cla_pkg.sv
package cla_pkg;
  localparam int CLA_WIDTH = 16;
  localparam int CLA_GROUP = 4;
endpackage

// File: rtl/cla_bitcells.sv
module cla_bitcells #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] prop,
  output logic [W-1:0] gen,
  output logic [W-1:0] half
);
  // Propagate uses OR; only the XOR term may feed the sum.
  assign prop = a | b;
  assign gen  = a & b;
  assign half = a ^ b;
endmodule

// File: rtl/cla_lookahead.sv
module cla_lookahead #(
  parameter int N = 4
) (
  input  logic [N-1:0] p,
  input  logic [N-1:0] g,
  input  logic         cin,
  output logic [N:0]   c,
  output logic         grp_p,
  output logic         grp_g
);
  // Flat two-level sums of products; the same unit serves both tiers.
  always_comb begin
    logic acc;
    logic term;
    c[0] = cin;
    for (int k = 1; k <= N; k++) begin
      acc = cin;
      for (int j = 0; j < k; j++) acc = acc & p[j];
      for (int j = 0; j < k; j++) begin
        term = g[j];
        for (int m = j + 1; m < k; m++) term = term & p[m];
        acc = acc | term;
      end
      c[k] = acc;
    end
  end

  always_comb begin
    logic accg;
    logic tg;
    grp_p = &p;
    accg  = 1'b0;
    for (int j = 0; j < N; j++) begin
      tg = g[j];
      for (int m = j + 1; m < N; m++) tg = tg & p[m];
      accg = accg | tg;
    end
    grp_g = accg;
  end

  always_comb begin
    if (!$isunknown({p, g, cin})) begin
      p_grp_gen_carry_r5: assert (!grp_g || c[N])
        else $error("group generate without carry out");
      p_grp_prop_carry_r5: assert (!(grp_p && cin) || c[N])
        else $error("propagated carry in lost");
      p_no_pg_no_carry_r5: assert (grp_p || grp_g || !c[N])
        else $error("carry out without generate or propagate");
    end
  end
endmodule

// File: rtl/cla_sumxor.sv
module cla_sumxor #(
  parameter int W = 16
) (
  input  logic [W-1:0] half,
  input  logic [W-1:0] carry,
  output logic [W-1:0] s
);
  assign s = half ^ carry;
endmodule

// File: rtl/cla16_adder.sv
module cla16_adder #(
  parameter int WIDTH = cla_pkg::CLA_WIDTH,
  parameter int GRP   = cla_pkg::CLA_GROUP
) (
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic             carry_in,
  output logic [WIDTH-1:0] sum,
  output logic             carry_out,
  output logic             blk_prop,
  output logic             blk_gen
);
  localparam int NGRP = WIDTH / GRP;

  logic [WIDTH-1:0] bp, bg, bx, carry;
  logic [NGRP-1:0]  gp, gg;
  logic [NGRP:0]    seed;

  cla_bitcells #(.W(WIDTH)) u_bits (
    .a(op_a), .b(op_b), .prop(bp), .gen(bg), .half(bx)
  );

  for (genvar j = 0; j < NGRP; j++) begin : g_tier1
    logic [GRP:0] c_loc;
    cla_lookahead #(.N(GRP)) u_la (
      .p(bp[j*GRP +: GRP]), .g(bg[j*GRP +: GRP]), .cin(seed[j]),
      .c(c_loc), .grp_p(gp[j]), .grp_g(gg[j])
    );
    assign carry[j*GRP +: GRP] = c_loc[GRP-1:0];

    always_comb begin
      if (!$isunknown({op_a, op_b, carry_in})) begin
        p_tier_agree_r2: assert (c_loc[GRP] == seed[j+1])
          else $error("group carry disagrees with next seed");
      end
    end
  end

  cla_lookahead #(.N(NGRP)) u_tier2 (
    .p(gp), .g(gg), .cin(carry_in),
    .c(seed), .grp_p(blk_prop), .grp_g(blk_gen)
  );

  assign carry_out = seed[NGRP];

  cla_sumxor #(.W(WIDTH)) u_sum (
    .half(bx), .carry(carry), .s(sum)
  );

  always_comb begin
    if (!$isunknown({op_a, op_b, carry_in})) begin
      p_sum_matches_r1: assert ({carry_out, sum} ==
                                ({1'b0, op_a} + {1'b0, op_b} + {{WIDTH{1'b0}}, carry_in}))
        else $error("sum mismatch");
      p_prop_or_r4: assert (blk_prop == (&(op_a | op_b)))
        else $error("block propagate wrong");
      p_gen_cout_r3: assert (!blk_gen || carry_out)
        else $error("block generate without carry out");
    end
  end
endmodule

// File: tb/test_cla16_adder.sv
module test_cla16_adder;
  logic        clk;
  logic [15:0] op_a, op_b, sum;
  logic        carry_in, carry_out, blk_prop, blk_gen;
  int          n_tests = 0;
  int          n_fail  = 0;
  bit          done    = 0;

  cla16_adder i_cla16_adder (
    .op_a(op_a), .op_b(op_b), .carry_in(carry_in),
    .sum(sum), .carry_out(carry_out), .blk_prop(blk_prop), .blk_gen(blk_gen)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h (a=%h b=%h cin=%b)",
               req, act, exp, op_a, op_b, carry_in);
    end
  endtask

  // Behavioural reference, compared once per clock.
  task automatic apply(input logic [15:0] a, input logic [15:0] b, input logic ci);
    int unsigned full, nocin;
    logic        ep;
    @(negedge clk);
    op_a = a; op_b = b; carry_in = ci;
    @(posedge clk); #1;
    full  = int'(a) + int'(b) + int'(ci);
    nocin = int'(a) + int'(b);
    ep    = ((a | b) == 16'hFFFF);
    chk(sum == full[15:0], "R1 sum", {16'h0, sum}, {16'h0, full[15:0]});
    chk(carry_out == full[16], "R2 carry_out", {31'h0, carry_out}, {31'h0, full[16]});
    chk(blk_gen == nocin[16], "R3 blk_gen", {31'h0, blk_gen}, {31'h0, nocin[16]});
    chk(blk_prop == ep, "R4 blk_prop", {31'h0, blk_prop}, {31'h0, ep});
    chk(carry_out == (blk_gen | (blk_prop & ci)), "R5 relation",
        {31'h0, carry_out}, {31'h0, blk_gen | (blk_prop & ci)});
  endtask

  // R6: group terms must not move when only carry_in changes.
  task automatic cin_indep(input logic [15:0] a, input logic [15:0] b);
    logic p0, g0;
    apply(a, b, 1'b0);
    p0 = blk_prop; g0 = blk_gen;
    apply(a, b, 1'b1);
    chk(blk_prop == p0, "R6 blk_prop vs carry_in", {31'h0, blk_prop}, {31'h0, p0});
    chk(blk_gen == g0, "R6 blk_gen vs carry_in", {31'h0, blk_gen}, {31'h0, g0});
  endtask

  initial begin
    op_a = '0; op_b = '0; carry_in = 1'b0;
    @(posedge clk); #1;
    chk(sum == 16'h0 && !carry_out, "R1 idle zeros", {15'h0, carry_out, sum}, 32'h0);
    apply(16'h0000, 16'h0000, 1'b0);
    apply(16'h0000, 16'h0000, 1'b1);
    apply(16'hFFFF, 16'hFFFF, 1'b0);
    apply(16'hFFFF, 16'hFFFF, 1'b1);
    apply(16'hFFFF, 16'h0000, 1'b1);
    chk(sum == 16'h0 && carry_out, "R7 full ripple", {15'h0, carry_out, sum}, 32'h1_0000);
    apply(16'hAAAA, 16'h5555, 1'b1);
    chk(sum == 16'h0 && carry_out, "R7 alt ripple", {15'h0, carry_out, sum}, 32'h1_0000);
    apply(16'hAAAA, 16'h5555, 1'b0);
    apply(16'h5555, 16'h5555, 1'b0);
    apply(16'h8000, 16'h8000, 1'b0);
    apply(16'h000F, 16'h0001, 1'b0);
    apply(16'h0FFF, 16'h0001, 1'b0);
    cin_indep(16'hFFFF, 16'h0000);
    cin_indep(16'h1234, 16'hFEDC);
    for (int i = 0; i < 3000; i++) begin
      apply(16'($urandom), 16'($urandom), 1'($urandom));
      if (i % 300 == 0) cin_indep(16'($urandom), 16'($urandom));
    end
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule